// File: doc/BRIEF.md
# I2C Target Write Receiver with Service Handshake

This block is the receive half of an I2C target. It watches already-synchronised SCL and SDA levels and finds start, repeated start and stop conditions. It compares the address byte with a programmed 7-bit address and acknowledges the data bytes that follow a write address. Those bytes are packed into a four-byte word, first byte lowest. When firmware has to take over, the block raises a data-ready flag and takes a snapshot of the word and of the number of valid bytes in it.

Three events raise data-ready: the programmed byte threshold is reached, a stop is seen, or a repeated start is seen. When the threshold is reached, the target also holds SCL low after the acknowledge bit. It keeps it low until the host has fetched the word. A host port reads the word, the byte count and a small status word. Every flag in the status word is cleared by the read that returns it. A clock-low watchdog flags SCL held low for too long, and a control input turns the watchdog off for plain I2C use.

Top module: `i2cr_slave_rx`

## Requirements
- R1: A write address (7-bit address equal to `own_addr`, direction bit 0) is acknowledged by driving `sda_drive` high during the ninth clock. Each following data byte is acknowledged the same way. The address byte is never stored in the word.
- R2: An address that does not match is not acknowledged. No byte is acknowledged and no flag is raised until the next start, and the reported count and word keep their previous values.
- R3: When the number of data bytes since the last data-ready event equals `ack_cnt`+1 (`ack_cnt` is 0..3), status bit 0 (data-ready) is set. The count reads `ack_cnt`+1 and the word holds byte i in bits [8i+7:8i].
- R4: A stop after an acknowledged write address sets data-ready. The count and word then hold the bytes received since the previous data-ready event, and the count may be zero.
- R5: A repeated start after an acknowledged write address sets data-ready, with the count and word of the bytes received before it.
- R6: A read of the status selector returns every pending flag at once and clears all of them. A second read returns zero unless a new event has occurred.
- R7: After the acknowledge bit of a threshold byte, `scl_hold` stays high until the word is read. It drops on the clock edge that takes that read.
- R8: If SCL stays low for `TMO_CYC` consecutive clock cycles, status bit 2 is set. While `tmo_dis` is high the flag is never set.
- R9: A matching address with direction bit 1 is not acknowledged and sets status bit 1.
- R10: After a start or repeated start, the byte count and packing position restart from zero. This happens after any pending data-ready event has been recorded.
- R11: After reset, the status word, count and word read zero, and neither `scl_hold` nor `sda_drive` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL bus level |
| sda_in | input | 1 | Synchronised SDA bus level |
| own_addr | input | 7 | Target address |
| ack_cnt | input | 2 | Byte threshold minus one |
| tmo_dis | input | 1 | Disables the clock-low watchdog |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | 0 word, 1 byte count, 2 status {tmo, nack, data-ready}, 3 zero |
| rd_data | output | 32 | Read data, valid while `rd_en` is high |
| scl_hold | output | 1 | Pull SCL low (clock stretch) |
| sda_drive | output | 1 | Pull SDA low (acknowledge) |

## Verification
The hardest case to reach is the clock stretch after a threshold byte. The bus must still be held while the host reads the status and count, and release must come exactly on the word read. The bench sweeps every threshold from one to four bytes. It models the bus as a wired-AND of its own master levels and the block's pull-downs. Between each threshold byte's acknowledge and the final stop it reads the host port with SCL still held. A restart followed by a read-direction address puts the data-ready and not-acknowledged flags in the same status word, so one read must clear both together.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int RX_BYTES = 4;
    localparam int RX_W     = RX_BYTES * 8;
    localparam int CNT_W    = $clog2(RX_BYTES + 1);
    localparam int IDX_W    = $clog2(RX_BYTES);
    localparam int ADR_W    = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_HOLD, S_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_WORD = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic tmo;
        logic nack;
        logic rdy;
    } status_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [RX_W-1:0] pack_byte(input logic [RX_W-1:0] word,
                                                  input logic [7:0]      data,
                                                  input logic [IDX_W-1:0] idx);
        return word | (RX_W'(data) << {idx, 3'b000});
    endfunction

endpackage

// File: rtl/i2cr_bus_mon.sv
module i2cr_bus_mon
    import i2cr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start = scl & scl_q &  sda_q & ~sda;
        ev.stop  = scl & scl_q & ~sda_q &  sda;
        ev.rise  = scl & ~scl_q;
        ev.fall  = ~scl & scl_q;
    end

endmodule

// File: rtl/i2cr_lowtmo.sv
module i2cr_lowtmo #(
    parameter int TMO_CYC = 3_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic dis,
    output logic hit
);
    localparam int TW = $clog2(TMO_CYC + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || scl || dis) begin
            cnt <= '0;
            hit <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (cnt < TW'(TMO_CYC)) cnt <= cnt + 1'b1;
            if (cnt == TW'(TMO_CYC - 1)) hit <= 1'b1;
        end
    end

    p_tmo_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        dis |=> !hit);

endmodule

// File: rtl/i2cr_rx_core.sv
module i2cr_rx_core
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             sda,
    input  logic [ADR_W-1:0] own_addr,
    input  logic [IDX_W-1:0] ack_cnt,
    input  logic             word_rd,
    output logic             rdy_set,
    output logic             nack_set,
    output logic [RX_W-1:0]  snap_word,
    output logic [CNT_W-1:0] snap_cnt,
    output logic             scl_hld,
    output logic             sda_drv
);
    rx_state_e        state;
    logic [7:0]       sreg;
    logic [2:0]       bitcnt;
    logic             byte_done;
    logic             active;
    logic             thr_pend;
    logic [RX_W-1:0]  live_word;
    logic [CNT_W-1:0] live_cnt;
    logic [RX_W-1:0]  placed;
    logic             addr_hit;

    assign placed   = pack_byte(live_word, sreg, live_cnt[IDX_W-1:0]);
    assign addr_hit = (sreg[7:1] == own_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            sreg      <= '0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            active    <= 1'b0;
            thr_pend  <= 1'b0;
            live_word <= '0;
            live_cnt  <= '0;
            snap_word <= '0;
            snap_cnt  <= '0;
            rdy_set   <= 1'b0;
            nack_set  <= 1'b0;
            scl_hld   <= 1'b0;
            sda_drv   <= 1'b0;
        end else begin
            rdy_set  <= 1'b0;
            nack_set <= 1'b0;
            if (ev.start || ev.stop) begin
                // record the pending transfer before restarting the count (R4, R5, R10)
                if (active) begin
                    rdy_set   <= 1'b1;
                    snap_word <= live_word;
                    snap_cnt  <= live_cnt;
                end
                live_word <= '0;
                live_cnt  <= '0;
                active    <= 1'b0;
                thr_pend  <= 1'b0;
                byte_done <= 1'b0;
                bitcnt    <= '0;
                sda_drv   <= 1'b0;
                scl_hld   <= 1'b0;
                state     <= ev.start ? S_ADDR : S_IDLE;
            end else begin
                unique case (state)
                    S_ADDR, S_DATA: begin
                        if (ev.rise) begin
                            sreg   <= {sreg[6:0], sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) byte_done <= 1'b1;
                        end else if (ev.fall && byte_done) begin
                            byte_done <= 1'b0;
                            if (state == S_ADDR) begin
                                if (addr_hit && !sreg[0]) begin
                                    sda_drv <= 1'b1;
                                    active  <= 1'b1;
                                    state   <= S_AACK;
                                end else begin
                                    nack_set <= addr_hit;
                                    state    <= S_SKIP;
                                end
                            end else begin
                                sda_drv <= 1'b1;
                                state   <= S_DACK;
                                if (live_cnt == CNT_W'(ack_cnt)) begin
                                    rdy_set   <= 1'b1;
                                    snap_word <= placed;
                                    snap_cnt  <= live_cnt + 1'b1;
                                    live_word <= '0;
                                    live_cnt  <= '0;
                                    thr_pend  <= 1'b1;
                                end else begin
                                    live_word <= placed;
                                    live_cnt  <= live_cnt + 1'b1;
                                end
                            end
                        end
                    end
                    S_AACK, S_DACK: begin
                        if (ev.fall) begin
                            sda_drv <= 1'b0;
                            bitcnt  <= '0;
                            if (thr_pend) begin
                                thr_pend <= 1'b0;
                                scl_hld  <= 1'b1;
                                state    <= S_HOLD;
                            end else begin
                                state <= S_DATA;
                            end
                        end
                    end
                    S_HOLD: begin
                        if (word_rd) begin
                            scl_hld <= 1'b0;
                            state   <= S_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_ack_slot_only_r1: assert property (@(posedge clk) disable iff (rst)
        sda_drv |-> (state == S_AACK || state == S_DACK));

    p_release_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && word_rd) |=> !scl_hld);

    p_hold_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (scl_hld && !word_rd && !ev.start && !ev.stop) |=> scl_hld);

    p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        snap_cnt <= CNT_W'(RX_BYTES));

endmodule

// File: rtl/i2cr_slave_rx.sv
module i2cr_slave_rx
    import i2cr_pkg::*;
#(
    parameter int TMO_CYC = 3_500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [ADR_W-1:0] own_addr,
    input  logic [IDX_W-1:0] ack_cnt,
    input  logic             tmo_dis,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [RX_W-1:0]  rd_data,
    output logic             scl_hold,
    output logic             sda_drive
);
    bus_ev_t          ev;
    logic             rdy_set, nack_set, tmo_hit;
    logic [RX_W-1:0]  snap_word;
    logic [CNT_W-1:0] snap_cnt;
    status_t          st_q;
    logic             word_rd, stat_rd;

    assign word_rd = rd_en && (rd_sel == SEL_WORD);
    assign stat_rd = rd_en && (rd_sel == SEL_STAT);

    i2cr_bus_mon u_mon (
        .clk (clk),
        .rst (rst),
        .scl (scl_in),
        .sda (sda_in),
        .ev  (ev)
    );

    i2cr_lowtmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk (clk),
        .rst (rst),
        .scl (scl_in),
        .dis (tmo_dis),
        .hit (tmo_hit)
    );

    i2cr_rx_core u_core (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda       (sda_in),
        .own_addr  (own_addr),
        .ack_cnt   (ack_cnt),
        .word_rd   (word_rd),
        .rdy_set   (rdy_set),
        .nack_set  (nack_set),
        .snap_word (snap_word),
        .snap_cnt  (snap_cnt),
        .scl_hld   (scl_hold),
        .sda_drv   (sda_drive)
    );

    // clear-on-read status; an event in the read cycle survives the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= (stat_rd ? status_t'('0) : st_q)
                  | status_t'({tmo_hit, nack_set, rdy_set});
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_WORD: rd_data = snap_word;
            SEL_CNT:  rd_data = RX_W'(snap_cnt);
            SEL_STAT: rd_data = RX_W'(st_q);
            default:  rd_data = '0;
        endcase
        if (!rd_en) rd_data = '0;
    end

    p_status_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rdy_set && !nack_set && !tmo_hit) |=> (st_q == '0));

    p_rdy_on_event_r4: assert property (@(posedge clk) disable iff (rst)
        rdy_set |=> st_q.rdy);

endmodule

// File: tb/i2cr_slave_rx_tb.sv
module i2cr_slave_rx_tb;
    localparam int TMO = 300;
    localparam int Q   = 4;
    localparam logic [6:0] OWN = 7'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0]  ack_cnt = 2'd0;
    logic        tmo_dis = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd3;
    logic [31:0] rd_data;
    logic        scl_hold, sda_drive;
    logic        scl_bus, sda_bus;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    assign scl_bus = scl_m & ~scl_hold;
    assign sda_bus = sda_m & ~sda_drive;

    always #2.5 clk = ~clk;

    i2cr_slave_rx #(.TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .own_addr(OWN), .ack_cnt(ack_cnt), .tmo_dis(tmo_dis),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .scl_hold(scl_hold), .sda_drive(sda_drive)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_high; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait_high; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; wait_high; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_high; tick(1);
        acked = ~sda_bus;
        tick(Q - 1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic host_rd(input logic [1:0] sel, output logic [31:0] d);
        rd_en = 1'b1; rd_sel = sel;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'd3;
    endtask

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'(8'hA5 ^ (k * 37 + i * 11 + 1));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp_w;
        logic        a;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R11 reset state
        host_rd(2'd2, d); check(d, 0, "R11 status");
        host_rd(2'd1, d); check(d, 0, "R11 count");
        host_rd(2'd0, d); check(d, 0, "R11 word");
        check({30'd0, scl_hold, sda_drive}, 0, "R11 pulls");

        // R3 / R7 sweep over every threshold
        for (int k = 0; k < 4; k++) begin
            ack_cnt = 2'(k);
            exp_w = '0;
            bus_start;
            send_byte({OWN, 1'b0}, a); check(32'(a), 1, "R1 address ack");
            for (int i = 0; i <= k; i++) begin
                send_byte(pat(k, i), a);
                check(32'(a), 1, "R1 data ack");
                exp_w |= 32'(pat(k, i)) << (8 * i);
            end
            tick(4);
            check(32'(scl_hold), 1, "R7 stretch held");
            host_rd(2'd2, d); check(d, 1, "R3 ready at threshold");
            host_rd(2'd1, d); check(d, 32'(k + 1), "R3 count");
            check(32'(scl_hold), 1, "R7 held until word read");
            host_rd(2'd0, d); check(d, exp_w, "R3 packed word");
            check(32'(scl_hold), 0, "R7 released after read");
            bus_stop;
            tick(3);
            host_rd(2'd2, d); check(d, 1, "R4 stop after threshold");
            host_rd(2'd1, d); check(d, 0, "R4 empty count");
        end

        // R4 stop with partial buffer
        ack_cnt = 2'd3;
        bus_start;
        send_byte({OWN, 1'b0}, a);
        send_byte(8'hC1, a);
        send_byte(8'h7E, a);
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 1, "R4 ready on stop");
        host_rd(2'd1, d); check(d, 2, "R4 count");
        host_rd(2'd0, d); check(d, 32'h7EC1, "R4 word");

        // R5 / R10 repeated start
        bus_start;
        send_byte({OWN, 1'b0}, a);
        send_byte(8'h3C, a);
        bus_start; tick(3);
        host_rd(2'd2, d); check(d, 1, "R5 ready on restart");
        host_rd(2'd1, d); check(d, 1, "R5 count");
        host_rd(2'd0, d); check(d, 32'h3C, "R5 word");
        send_byte({OWN, 1'b0}, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 1, "R10 ready");
        host_rd(2'd1, d); check(d, 3, "R10 count restarted");
        host_rd(2'd0, d); check(d, 32'h332211, "R10 word restarted");

        // R2 non-matching addresses
        for (int j = 0; j < 4; j++) begin
            bus_start;
            send_byte({OWN ^ 7'(1 << j), 1'b0}, a); check(32'(a), 0, "R2 address nack");
            send_byte(8'h55, a); check(32'(a), 0, "R2 data ignored");
            bus_stop; tick(3);
            host_rd(2'd2, d); check(d, 0, "R2 no flags");
            host_rd(2'd1, d); check(d, 3, "R2 count kept");
        end

        // R9 read direction
        bus_start;
        send_byte({OWN, 1'b1}, a); check(32'(a), 0, "R9 read not acked");
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 2, "R9 nack flag");

        // R6 several flags cleared together
        bus_start;
        send_byte({OWN, 1'b0}, a);
        send_byte(8'h99, a);
        bus_start;
        send_byte({OWN, 1'b1}, a);
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 3, "R6 combined flags");
        host_rd(2'd2, d); check(d, 0, "R6 cleared by read");

        // R8 clock-low watchdog
        tmo_dis = 1'b0;
        bus_start;
        tick(TMO + 20);
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 4, "R8 timeout flag");
        tmo_dis = 1'b1;
        bus_start;
        tick(TMO + 20);
        bus_stop; tick(3);
        host_rd(2'd2, d); check(d, 0, "R8 disabled");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule